// File: doc/BRIEF.md
# Complementary PWM Dead-Time Inserter

This block turns a single PWM waveform bit, coming from a timer compare channel, into a complementary pair of gate drives: a high-side drive that follows the waveform and a low-side drive that follows its inverse. After every transition of the waveform, both drives are held inactive for a programmable number of clock cycles. This gap stops the two switches of a half bridge from ever conducting at the same time.

The gap that follows a rising waveform edge and the gap that follows a falling edge are set separately, each as an 8-bit cycle count. One shared down-counter produces both gaps. It is reloaded with one setting or the other, depending on the direction of the edge.

Software writes each setting into a staging register, which sets a pending flag. A timer update strobe then moves every pending setting into its working register, so that a new gap pair takes effect at a period boundary chosen by the timer.

Top module: `pwm_deadtime_pair`

## Requirements
- R1: While reset is high, both drives are low. After reset, both working gap settings equal the parameter RESET_DT (default 0) and no staging value is pending.
- R2: While the gap counter is zero, the high-side drive equals the waveform and the low-side drive equals its inverse, each registered one cycle after the waveform is sampled.
- R3: A rising waveform edge holds both drives low for exactly as many cycles as the working low-side setting. The high-side drive then goes high.
- R4: A falling waveform edge holds both drives low for exactly as many cycles as the working high-side setting. The low-side drive then goes high.
- R5: The two drives are never high in the same cycle.
- R6: When no edge is present, a nonzero gap count decreases by one each cycle, and a zero count stays at zero.
- R7: A setting of zero gives no gap: the drives switch on the first clock edge after the waveform changes.
- R8: Writing a staging register without an update strobe leaves the gap that edges produce unchanged.
- R9: An update strobe copies each pending staging value into its working register and clears that value's pending flag. An update strobe with nothing pending changes nothing.
- R10: When a write and an update strobe occur in the same cycle, the working register takes the staging value held before that write. The new value stays pending and is applied by the next update strobe.
- R11: An edge that arrives while a gap is still counting restarts the count from the setting for the new edge direction. Both drives stay low until that new count runs out.
- R12: The low-side and high-side settings are independent: writing and updating one leaves the gap of the other unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous reset, active high |
| wave_in | input | 1 | PWM waveform bit from the compare channel |
| wr_data | input | DT_W (8) | Setting value shared by both write strobes |
| wr_lo_en | input | 1 | Writes wr_data into the low-side staging register (rising-edge gap) |
| wr_hi_en | input | 1 | Writes wr_data into the high-side staging register (falling-edge gap) |
| upd_stb | input | 1 | Timer update strobe; moves pending staging values into the working registers |
| lo_drv | output | 1 | Low-side gate drive, high means on |
| hi_drv | output | 1 | High-side gate drive, high means on |

## Verification
The hardest situation to reach is an edge that lands in the middle of a gap that is still counting. Here the restarted count must come from the other setting, and no cycle with a drive high may appear between the two gaps. The stimulus sets a long rising-edge gap and a short falling-edge gap. It then drives a falling edge three cycles into the long gap and counts the inactive cycles that follow. The other hard case is a write and an update in the same cycle. It is reached by staging one value and then writing a second value together with the strobe, after which the gaps produced by later edges show which value was applied at each step.

// File: rtl/dt_pkg.sv
package dt_pkg;

  // Classification of the waveform change seen at the current clock edge.
  typedef enum logic [1:0] {
    EDGE_NONE = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_FALL = 2'd2
  } edge_kind_t;

  // Index of each setting in the staging array.
  localparam int SEL_LO = 0;
  localparam int SEL_HI = 1;
  localparam int NUM_SETTINGS = 2;

endpackage

// File: rtl/dt_shadow_reg.sv
module dt_shadow_reg #(
  parameter int W = 8,
  parameter logic [W-1:0] RESET_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         upd_stb,
  output logic [W-1:0] active_q
);

  logic [W-1:0] stage_q;
  logic         pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q  <= '0;
      pend_q   <= 1'b0;
      active_q <= RESET_VAL;
    end else begin
      // The copy uses the staging value held before any write in this cycle.
      if (upd_stb && pend_q) begin
        active_q <= stage_q;
      end
      if (wr_en) begin
        stage_q <= wr_data;
        pend_q  <= 1'b1;
      end else if (upd_stb) begin
        pend_q  <= 1'b0;
      end
    end
  end

  assert_pend_kept_R10: assert property (@(posedge clk) disable iff (rst)
    (wr_en && upd_stb) |=> pend_q);

  assert_pend_cleared_R9: assert property (@(posedge clk) disable iff (rst)
    (upd_stb && !wr_en) |=> !pend_q);

  assert_active_held_R8: assert property (@(posedge clk) disable iff (rst)
    !upd_stb |=> $stable(active_q));

endmodule

// File: rtl/dt_gap_counter.sv
module dt_gap_counter
  import dt_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wave_in,
  input  logic [W-1:0] lo_val,
  input  logic [W-1:0] hi_val,
  output logic [W-1:0] cnt_q,
  output logic         zero_nxt
);

  logic         wave_q;
  edge_kind_t   edge_kind;
  logic [W-1:0] cnt_nxt;

  always_comb begin
    if (wave_in && !wave_q)      edge_kind = EDGE_RISE;
    else if (!wave_in && wave_q) edge_kind = EDGE_FALL;
    else                         edge_kind = EDGE_NONE;
  end

  always_comb begin
    unique case (edge_kind)
      EDGE_RISE: cnt_nxt = lo_val;
      EDGE_FALL: cnt_nxt = hi_val;
      default:   cnt_nxt = (cnt_q != '0) ? cnt_q - 1'b1 : '0;
    endcase
  end

  assign zero_nxt = (cnt_nxt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      wave_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      wave_q <= wave_in;
      cnt_q  <= cnt_nxt;
    end
  end

  assert_count_down_R6: assert property (@(posedge clk) disable iff (rst)
    (cnt_q != '0 && edge_kind == EDGE_NONE) |=> (cnt_q == $past(cnt_q) - 1'b1));

  assert_hold_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == '0 && edge_kind == EDGE_NONE) |=> (cnt_q == '0));

  assert_restart_R11: assert property (@(posedge clk) disable iff (rst)
    (edge_kind == EDGE_FALL) |=> (cnt_q == $past(hi_val)));

endmodule

// File: rtl/dt_drive_stage.sv
module dt_drive_stage (
  input  logic clk,
  input  logic rst,
  input  logic wave_nxt,
  input  logic gap_done,
  output logic lo_drv,
  output logic hi_drv
);

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_drv <= 1'b0;
      hi_drv <= 1'b0;
    end else begin
      hi_drv <= gap_done & wave_nxt;
      lo_drv <= gap_done & ~wave_nxt;
    end
  end

  assert_no_overlap_R5: assert property (@(posedge clk) disable iff (rst)
    !(lo_drv && hi_drv));

endmodule

// File: rtl/pwm_deadtime_pair.sv
module pwm_deadtime_pair
  import dt_pkg::*;
#(
  parameter int DT_W = 8,
  parameter logic [DT_W-1:0] RESET_DT = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wave_in,
  input  logic [DT_W-1:0] wr_data,
  input  logic            wr_lo_en,
  input  logic            wr_hi_en,
  input  logic            upd_stb,
  output logic            lo_drv,
  output logic            hi_drv
);

  logic [DT_W-1:0]         act_val [NUM_SETTINGS];
  logic [NUM_SETTINGS-1:0] wr_sel;
  logic [DT_W-1:0]         cnt_q;
  logic                    zero_nxt;

  always_comb begin
    wr_sel         = '0;
    wr_sel[SEL_LO] = wr_lo_en;
    wr_sel[SEL_HI] = wr_hi_en;
  end

  for (genvar i = 0; i < NUM_SETTINGS; i++) begin : g_setting
    dt_shadow_reg #(
      .W         (DT_W),
      .RESET_VAL (RESET_DT)
    ) u_shadow (
      .clk      (clk),
      .rst      (rst),
      .wr_en    (wr_sel[i]),
      .wr_data  (wr_data),
      .upd_stb  (upd_stb),
      .active_q (act_val[i])
    );
  end

  dt_gap_counter #(.W(DT_W)) u_counter (
    .clk      (clk),
    .rst      (rst),
    .wave_in  (wave_in),
    .lo_val   (act_val[SEL_LO]),
    .hi_val   (act_val[SEL_HI]),
    .cnt_q    (cnt_q),
    .zero_nxt (zero_nxt)
  );

  dt_drive_stage u_drive (
    .clk      (clk),
    .rst      (rst),
    .wave_nxt (wave_in),
    .gap_done (zero_nxt),
    .lo_drv   (lo_drv),
    .hi_drv   (hi_drv)
  );

  assert_off_in_gap_R3: assert property (@(posedge clk) disable iff (rst)
    (cnt_q != '0) |-> (!lo_drv && !hi_drv));

  assert_follow_R2: assert property (@(posedge clk) disable iff (rst)
    (zero_nxt) |=> (hi_drv == $past(wave_in)) && (lo_drv == !$past(wave_in)));

endmodule

// File: tb/pwm_deadtime_pair_test.sv
`timescale 1ns/1ps
module pwm_deadtime_pair_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wave_in = 1'b0;
  logic [7:0] wr_data = '0;
  logic       wr_lo_en = 1'b0;
  logic       wr_hi_en = 1'b0;
  logic       upd_stb = 1'b0;
  logic       lo_drv;
  logic       hi_drv;

  int  total = 0;
  int  bad = 0;
  bit  finished = 1'b0;

  always #2.5 clk = ~clk;

  pwm_deadtime_pair uut (
    .clk      (clk),
    .rst      (rst),
    .wave_in  (wave_in),
    .wr_data  (wr_data),
    .wr_lo_en (wr_lo_en),
    .wr_hi_en (wr_hi_en),
    .upd_stb  (upd_stb),
    .lo_drv   (lo_drv),
    .hi_drv   (hi_drv)
  );

  // Each entry: {rising-edge gap, falling-edge gap}
  localparam logic [15:0] VEC [6] = '{
    {8'd0,   8'd0},
    {8'd1,   8'd5},
    {8'd7,   8'd2},
    {8'd255, 8'd3},
    {8'd12,  8'd0},
    {8'd0,   8'd9}
  };

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic program_pair(input logic [7:0] lo, input logic [7:0] hi);
    @(negedge clk); wr_lo_en = 1'b1; wr_data = lo;
    @(negedge clk); wr_lo_en = 1'b0; wr_hi_en = 1'b1; wr_data = hi;
    @(negedge clk); wr_hi_en = 1'b0; upd_stb = 1'b1;
    @(negedge clk); upd_stb = 1'b0;
  endtask

  // Drive a new waveform level and count the cycles with both drives low.
  task automatic measure(input logic lvl, output int gap);
    @(negedge clk); wave_in = lvl;
    gap = 0;
    while (gap < 400) begin
      @(negedge clk);
      if (!lo_drv && !hi_drv) gap++;
      else break;
    end
  endtask

  task automatic edge_pair(input string tag, input int exp_lo, input int exp_hi);
    int g;
    measure(1'b1, g);
    check({tag, " rise gap"}, g, exp_lo);
    check({tag, " hi on after rise"}, {30'd0, hi_drv, lo_drv}, 2);
    measure(1'b0, g);
    check({tag, " fall gap"}, g, exp_hi);
    check({tag, " lo on after fall"}, {30'd0, hi_drv, lo_drv}, 1);
  endtask

  initial begin
    int g;
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 drives low in reset", {30'd0, hi_drv, lo_drv}, 0);
    rst = 1'b0;
    @(negedge clk);
    // R2: counter zero, waveform low -> low side on
    check("R2 follow inverse", {30'd0, hi_drv, lo_drv}, 1);
    // R1/R7: working settings reset to zero -> no gap
    edge_pair("R1 R7 reset settings", 0, 0);

    // Table of settings, one loop: R3 R4 R7
    for (int i = 0; i < 6; i++) begin
      program_pair(VEC[i][15:8], VEC[i][7:0]);
      edge_pair("R3 R4 table", int'(VEC[i][15:8]), int'(VEC[i][7:0]));
    end

    // R8: staged write without update has no effect
    program_pair(8'd4, 8'd6);
    @(negedge clk); wr_lo_en = 1'b1; wr_data = 8'd20;
    @(negedge clk); wr_lo_en = 1'b0;
    edge_pair("R8 staged only", 4, 6);

    // R9: update applies pending value; R12: high side untouched
    @(negedge clk); upd_stb = 1'b1;
    @(negedge clk); upd_stb = 1'b0;
    edge_pair("R9 R12 lo update", 20, 6);
    // R9: update with nothing pending changes nothing
    @(negedge clk); upd_stb = 1'b1;
    @(negedge clk); upd_stb = 1'b0;
    edge_pair("R9 empty update", 20, 6);

    // R10: write together with update
    @(negedge clk); wr_hi_en = 1'b1; wr_data = 8'd3;
    @(negedge clk); wr_data = 8'd11; upd_stb = 1'b1;
    @(negedge clk); wr_hi_en = 1'b0; upd_stb = 1'b0;
    edge_pair("R10 old staged applied", 20, 3);
    @(negedge clk); upd_stb = 1'b1;
    @(negedge clk); upd_stb = 1'b0;
    edge_pair("R10 kept pending applied", 20, 11);

    // R11: falling edge in the middle of a rising gap
    program_pair(8'd10, 8'd4);
    @(negedge clk); wave_in = 1'b1;
    g = 0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      if (!lo_drv && !hi_drv) g++;
    end
    check("R11 off before restart", g, 3);
    measure(1'b0, g);
    check("R11 restarted gap", g, 4);
    check("R11 lo on after restart", {30'd0, hi_drv, lo_drv}, 1);

    // R5: reset mid-gap returns both low
    @(negedge clk); wave_in = 1'b1;
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    check("R1 reset mid gap", {30'd0, hi_drv, lo_drv}, 0);
    rst = 1'b0; wave_in = 1'b0;
    @(negedge clk);
    check("R5 R2 after reset", {30'd0, hi_drv, lo_drv}, 1);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule